// File: doc/BRIEF.md
# Dual-Acknowledge Interrupt Controller

This block collects fifteen interrupt lines for a single processor and presents the highest-priority active one as a 4-bit level. Each line becomes active when it is pending (latched from a rising input edge) or forced (set by software), and it is also enabled in the enable mask. Level 0 means nothing is requested. Software reaches the registers through a simple synchronous register bus with a combinational read path.

An interrupt can be retired in two ways, and both use the same clear operation. The processor acknowledges implicitly by pulsing an acknowledge strobe with the level it is entering. Software acknowledges explicitly by writing a bit mask to the clear register. Either path removes the selected bits from both the pending and the force registers, and the output level is re-evaluated from the updated registers. If software clears a request that is still being presented, the level drops before any handler is entered.

Top module: `intc_dualack`

## Requirements
- R1: After reset, irqLevel is 0 and the level, pending, force and enable-mask registers all read 0.
- R2: A rising edge on irqIn[k] (k = 1..15) sets pending bit k. A line that stays high does not set its bit again after it is cleared.
- R3: irqLevel equals the highest k for which (pending[k] | force[k]) & mask[k] is 1. It is 0 when no such k exists.
- R4: A line whose mask bit is 0 does not affect irqLevel, but its pending bit is kept and can still be read.
- R5: A bus write of value V to offset 0x0C clears pending[k] and force[k] for every k set in V[15:1]. irqLevel reflects the result in the cycle after the write.
- R6: Bit 0 of every register reads 0, and bit 0 of a value written to any register, including the clear register, has no effect.
- R7: A cycle with ackValid=1 and ackLevel=n (1..15) clears pending[n] and force[n] and no other bit. With ackLevel=0 the acknowledge has no effect.
- R8: When a rising edge on line k and a clear of bit k (by bus or by acknowledge) occur in the same cycle, pending[k] ends up set.
- R9: Writing force bit k makes line k active, with no input edge, until bit k is cleared.
- R10: Register offsets: 0x00 holds the current level in bits 3:0 and is read-only. 0x04 (pending), 0x08 (force) and 0x40 (enable mask) are read/write with lines in bits 15:1. 0x0C (clear) is write-only and reads 0. Any other offset reads 0.
- R11: A processor acknowledge and a software clear in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 15 | Interrupt lines 15..1, rising-edge sensitive |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from busAddr) |
| ackValid | input | 1 | Processor acknowledge strobe |
| ackLevel | input | 4 | Level being acknowledged |
| irqLevel | output | 4 | Requested interrupt level, 0 = none |

## Verification
The bench uses the default parameters: fifteen lines, an 8-bit offset and a 32-bit data word. With these values both ends of the priority order (lines 1 and 15) can be reached, every acknowledge level from 0 to 15 can be driven, and the unused bit 0 of the line vector stays visible on the bus. This makes the edge-versus-clear collision, the combined acknowledge and software clear, and the withdrawal of an already presented level all observable at the ports.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

  localparam int OFF_LEVEL = 'h00;
  localparam int OFF_PEND  = 'h04;
  localparam int OFF_FORCE = 'h08;
  localparam int OFF_CLEAR = 'h0C;
  localparam int OFF_MASK  = 'h40;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_LEVEL = 3'd1,
    RD_PEND  = 3'd2,
    RD_FORCE = 3'd3,
    RD_MASK  = 3'd4
  } rd_sel_e;

  typedef struct packed {
    logic    wrPend;
    logic    wrForce;
    logic    wrMask;
    logic    swClr;
    logic    hwClr;
    rd_sel_e rdSel;
  } intc_strb_t;

endpackage

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 15,
  parameter int LVL_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output intc_strb_t        strb
);

  logic wrEn;
  logic ackInRange;

  assign wrEn       = busSel && busWrite;
  assign ackInRange = (ackLevel != '0) && (int'(ackLevel) <= NUM_LINES);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (busSel) begin
      case (busAddr)
        ADDR_W'(OFF_LEVEL): strb.rdSel = RD_LEVEL;
        ADDR_W'(OFF_PEND): begin
          strb.rdSel  = RD_PEND;
          strb.wrPend = wrEn;
        end
        ADDR_W'(OFF_FORCE): begin
          strb.rdSel   = RD_FORCE;
          strb.wrForce = wrEn;
        end
        ADDR_W'(OFF_MASK): begin
          strb.rdSel  = RD_MASK;
          strb.wrMask = wrEn;
        end
        ADDR_W'(OFF_CLEAR): strb.swClr = wrEn;
        default: ;
      endcase
    end
    strb.hwClr = ackValid && ackInRange;
  end

  // R10: one bus write reaches at most one register per cycle
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrPend, strb.wrForce, strb.wrMask, strb.swClr}));

endmodule

// File: rtl/intc_dp.sv
`timescale 1ns/1ps
module intc_dp
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int LVL_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  intc_strb_t         strb,
  input  logic [LVL_W-1:0]   ackIdx,
  input  logic [NUM_LINES:1] irqIn,
  input  logic [NUM_LINES:1] wLines,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [DATA_W-1:0]  rdata
);

  logic [NUM_LINES:1] pendReg, forceReg, maskReg, irqPrev;
  logic [NUM_LINES:1] riseVec, hwMask, clrVec, activeVec;
  logic [NUM_LINES:1] pendNext, forceNext;
  logic [NUM_LINES:0] actFull;

  assign riseVec = irqIn & ~irqPrev;

  for (genvar k = 1; k <= NUM_LINES; k++) begin : g_line
    assign hwMask[k] = strb.hwClr && (ackIdx == LVL_W'(k));
    // one clear operation shared by both acknowledge paths; a new edge wins
    assign pendNext[k]  = ((strb.wrPend ? wLines[k] : pendReg[k]) & ~clrVec[k])
                          | riseVec[k];
    assign forceNext[k] = (strb.wrForce ? wLines[k] : forceReg[k]) & ~clrVec[k];
  end

  assign clrVec    = (strb.swClr ? wLines : '0) | hwMask;
  assign activeVec = (pendReg | forceReg) & maskReg;
  assign actFull   = {activeVec, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendReg  <= '0;
      forceReg <= '0;
      maskReg  <= '0;
      irqPrev  <= '0;
    end else begin
      pendReg  <= pendNext;
      forceReg <= forceNext;
      irqPrev  <= irqIn;
      if (strb.wrMask) maskReg <= wLines;
    end
  end

  always_comb begin
    irqLevel = '0;
    for (int k = 1; k <= NUM_LINES; k++) begin
      if (activeVec[k]) irqLevel = LVL_W'(k);
    end
  end

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      RD_LEVEL: rdata[LVL_W-1:0]   = irqLevel;
      RD_PEND:  rdata[NUM_LINES:1] = pendReg;
      RD_FORCE: rdata[NUM_LINES:1] = forceReg;
      RD_MASK:  rdata[NUM_LINES:1] = maskReg;
      default:  rdata = '0;
    endcase
  end

  // R3: a nonzero level names an active line with nothing above it
  a_r3_level_top: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLevel != '0) |-> ((actFull >> irqLevel) == (NUM_LINES+1)'(1)));
  // R3: level 0 only when no line is active
  a_r3_level_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLevel == '0) |-> (actFull == '0));
  // R5: a software clear leaves no force bit of its mask set
  a_r5_sw_clears_force: assert property (@(posedge clk) disable iff (!rst_n)
    strb.swClr |=> ((forceReg & $past(wLines)) == '0));
  // R7: processor acknowledge clears its bit and leaves the others
  a_r7_ack_only_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hwClr && !strb.swClr && !strb.wrForce) |=>
      ((forceReg & $past(hwMask)) == '0) &&
      ((forceReg | $past(hwMask)) == ($past(forceReg) | $past(hwMask))));
  // R8: an input edge is never lost to a clear in the same cycle
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (riseVec != '0) |=> ((pendReg & $past(riseVec)) == $past(riseVec)));

endmodule

// File: rtl/intc_dualack.sv
`timescale 1ns/1ps
module intc_dualack
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 15,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  localparam int LVL_W    = $clog2(NUM_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LINES:1] irqIn,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               ackValid,
  input  logic [LVL_W-1:0]   ackLevel,
  output logic [LVL_W-1:0]   irqLevel
);

  intc_strb_t         strb;
  logic [NUM_LINES:1] wLines;
  logic               unusedWdata;

  assign wLines      = busWdata[NUM_LINES:1];
  assign unusedWdata = ^{busWdata[0], busWdata[DATA_W-1:NUM_LINES+1]};

  intc_ctrl #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .ackValid (ackValid),
    .ackLevel (ackLevel),
    .strb     (strb)
  );

  intc_dp #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .ackIdx   (ackLevel),
    .irqIn    (irqIn),
    .wLines   (wLines),
    .irqLevel (irqLevel),
    .rdata    (busRdata)
  );

endmodule

// File: tb/intc_dualack_test.sv
`timescale 1ns/1ps
module intc_dualack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] irqIn = '0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        ackValid = 1'b0;
  logic [3:0]  ackLevel = '0;
  logic [3:0]  irqLevel;

  int nRun = 0, nFail = 0;

  intc_dualack uut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ackValid(ackValid), .ackLevel(ackLevel), .irqLevel(irqLevel)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [15:0] lines;
    logic [15:0] mask;
    logic [15:0] forceV;
    logic [3:0]  level;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h0004, 16'hFFFE, 16'h0000, 4'd2},
    '{16'h8002, 16'hFFFE, 16'h0000, 4'd15},
    '{16'h8002, 16'h7FFE, 16'h0000, 4'd1},
    '{16'h0000, 16'hFFFE, 16'h0200, 4'd9},
    '{16'h0010, 16'h0010, 16'h1000, 4'd4},
    '{16'h0000, 16'h0000, 16'hFFFE, 4'd0},
    '{16'h00A0, 16'h00A0, 16'h0000, 4'd7},
    '{16'h0000, 16'hFFFE, 16'h0000, 4'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [7:0] a, logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulse(logic [15:1] v);
    irqIn = irqIn | v;
    @(posedge clk); @(negedge clk);
    irqIn = irqIn & ~v;
  endtask

  task automatic ack(logic [3:0] n);
    ackValid = 1'b1; ackLevel = n;
    @(posedge clk); @(negedge clk);
    ackValid = 1'b0; ackLevel = '0;
  endtask

  task automatic wipe();
    irqIn = '0;
    busWr(8'h40, 32'h0);
    busWr(8'h08, 32'h0);
    busWr(8'h0C, 32'hFFFE);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1 check("R1 level out", {28'h0, irqLevel}, 32'h0);
    busRd(8'h00, rd); check("R1 level reg", rd, 32'h0);
    busRd(8'h04, rd); check("R1 pending", rd, 32'h0);
    busRd(8'h08, rd); check("R1 force", rd, 32'h0);
    busRd(8'h40, rd); check("R1 mask", rd, 32'h0);
    @(negedge clk);

    // R3 priority over the vector table
    for (int i = 0; i < 8; i++) begin
      wipe();
      busWr(8'h40, {16'h0, VECS[i].mask});
      busWr(8'h08, {16'h0, VECS[i].forceV});
      if (VECS[i].lines != 16'h0) pulse(VECS[i].lines[15:1]);
      #1 check($sformatf("R3 vector %0d", i), {28'h0, irqLevel}, {28'h0, VECS[i].level});
      @(negedge clk);
    end

    // R10 register map
    wipe();
    busWr(8'h04, 32'h0000_0030);
    busWr(8'h40, 32'h0000_FFFE);
    busRd(8'h00, rd); check("R10 level reg reads 5", rd, 32'h5);
    @(negedge clk);
    busWr(8'h00, 32'hFFFF_FFFF);
    busRd(8'h00, rd); check("R10 level reg read-only", rd, 32'h5);
    busRd(8'h0C, rd); check("R10 clear reads 0", rd, 32'h0);
    busRd(8'h20, rd); check("R10 unmapped reads 0", rd, 32'h0);
    @(negedge clk);

    // R6 bit 0 ignored
    busWr(8'h04, 32'hFFFF_FFFF);
    busRd(8'h04, rd); check("R6 pending bit0 and upper", rd, 32'h0000_FFFE);
    @(negedge clk);
    busWr(8'h0C, 32'h0000_0001);
    busRd(8'h04, rd); check("R6 clear bit0 no effect", rd, 32'h0000_FFFE);
    @(negedge clk);

    // R5 software clear withdraws a presented level
    wipe();
    busWr(8'h40, 32'h0000_FFFE);
    pulse(15'h0020); // line 6
    #1 check("R5 presented 6", {28'h0, irqLevel}, 32'h6);
    @(negedge clk);
    busWr(8'h0C, 32'h0000_0040);
    #1 check("R5 level dropped", {28'h0, irqLevel}, 32'h0);
    busRd(8'h04, rd); check("R5 pending cleared", rd, 32'h0);
    @(negedge clk);
    busWr(8'h08, 32'h0000_0400);
    #1 check("R9 force line 10", {28'h0, irqLevel}, 32'hA);
    @(negedge clk);
    busWr(8'h0C, 32'h0000_0400);
    busRd(8'h08, rd); check("R5 force cleared", rd, 32'h0);
    #1 check("R9 level after force clear", {28'h0, irqLevel}, 32'h0);
    @(negedge clk);

    // R4 masked line keeps pending
    busWr(8'h40, 32'h0);
    pulse(15'h0004); // line 3
    #1 check("R4 masked level", {28'h0, irqLevel}, 32'h0);
    busRd(8'h04, rd); check("R4 pending kept", rd, 32'h0000_0008);
    @(negedge clk);

    // R7 processor acknowledge
    wipe();
    busWr(8'h40, 32'h0000_FFFE);
    busWr(8'h04, 32'h0000_0030);
    busWr(8'h08, 32'h0000_0040);
    ack(4'd6);
    busRd(8'h08, rd); check("R7 ack 6 clears force", rd, 32'h0);
    busRd(8'h04, rd); check("R7 ack 6 keeps pending", rd, 32'h0000_0030);
    @(negedge clk);
    ack(4'd5);
    busRd(8'h04, rd); check("R7 ack 5 only bit 5", rd, 32'h0000_0010);
    #1 check("R7 level after ack", {28'h0, irqLevel}, 32'h4);
    @(negedge clk);
    ack(4'd0);
    busRd(8'h04, rd); check("R7 ack 0 no effect", rd, 32'h0000_0010);
    @(negedge clk);

    // R11 ack and software clear together
    busWr(8'h04, 32'h0000_0300);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h0C; busWdata = 32'h0000_0100;
    ackValid = 1'b1; ackLevel = 4'd9;
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; ackValid = 1'b0; ackLevel = '0;
    busRd(8'h04, rd); check("R11 both clears applied", rd, 32'h0);
    @(negedge clk);

    // R8 edge wins over same-cycle clear
    busWr(8'h04, 32'h0000_0008);
    irqIn[3] = 1'b1;
    busWr(8'h0C, 32'h0000_0008);
    busRd(8'h04, rd); check("R8 edge wins", rd, 32'h0000_0008);
    @(negedge clk);

    // R2 held-high line does not re-set pending
    busWr(8'h0C, 32'h0000_0008);
    repeat (3) @(negedge clk);
    busRd(8'h04, rd); check("R2 no re-trigger while high", rd, 32'h0);
    @(negedge clk);
    irqIn[3] = 1'b0;
    @(negedge clk);
    pulse(15'h0004);
    busRd(8'h04, rd); check("R2 new edge sets pending", rd, 32'h0000_0008);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule